// File: doc/BRIEF.md
# Keyboard Key Latch with Acknowledge Strobe

This block sits between a key-code producer and the I/O space of an 8-bit CPU. Codes arrive on a valid/ready stream. Each accepted code is first remapped: a line feed becomes a carriage return, a delete becomes a backspace, and bit 7 is forced high. The result is then held in a single byte latch. Bit 7 of that byte is the "key waiting" flag. The CPU polls the latch at a data address. It acknowledges the key by touching a second address, the strobe address, with either a read or a write. The acknowledge clears bit 7 and keeps the character bits.

Back-pressure on the stream works as follows. `key_ready` is high whenever the flag is clear. While the flag is set, `key_ready` stays low until the producer has held `key_valid` high for `HOLD_CYCLES` consecutive cycles. After that, `key_ready` rises and the pending code overwrites the unacknowledged one. A transfer happens on a rising clock edge where `key_valid` and `key_ready` are both high. Once `key_valid` is raised, the producer must keep it high, with `key_code` stable, until the transfer happens.

Read data is combinational. `bus_rd_hit` marks a read that this block answers. Writes to the data address are ignored, because that address belongs to another write-only switch.

Top module: `kbd_latch`

## Requirements
- R1: After reset the latch holds 0x00, `key_ready` is high, and a read of the data address (default 0xC000) returns 0x00.
- R2: A read of the data address returns the latched byte in the same cycle with `bus_rd_hit` high. After a transfer, bit 7 of the latch is 1.
- R3: An accepted code other than 0x0A and 0x7F is latched as the code ORed with 0x80. This includes codes whose bit 7 is already set.
- R4: An accepted 0x0A is latched as 0x8D.
- R5: An accepted 0x7F is latched as 0x88.
- R6: A read of the strobe address (default 0xC010) returns the latched byte with bit 7 forced to 0, with `bus_rd_hit` high. From the next cycle, the latch has bit 7 cleared and bits 6..0 unchanged.
- R7: A write to the strobe address clears bit 7 of the latch and leaves bits 6..0 unchanged.
- R8: `key_ready` is high whenever latch bit 7 is 0. It is low while bit 7 is 1 and the hold-off has not elapsed.
- R9: While bit 7 is 1 and `key_valid` is held, `key_ready` stays low for exactly `HOLD_CYCLES` cycles. It then rises, and the new code overwrites the latch.
- R10: A write to the data address, and any access to another address, leave the latch unchanged. A read of another address returns 0x00 with `bus_rd_hit` low.
- R11: When a transfer and a strobe access fall in the same cycle, the new code is latched with bit 7 set. The strobe read returns the old byte with bit 7 cleared.
- R12: The producer holds `key_valid` high and `key_code` stable from the cycle it raises `key_valid` until the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Producer offers a key code |
| key_ready | output | 1 | Latch will take the offered code this cycle |
| key_code | input | 8 | Raw key code from the producer |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_rdata | output | 8 | Read data; 0x00 when not selected |
| bus_rd_hit | output | 1 | The current read targets this block |

## Verification
The checks assume that the producer obeys the stream rule in R12. Once `key_valid` is raised, it stays high with an unchanging code until the transfer. They also assume that `bus_rd` and `bus_wr` are never high together. The stimulus drives each key from one task. That task raises valid and the code together on a falling edge and drops them only after it has seen `key_ready` high before a rising edge. Every CPU access is a single-cycle pulse of one strobe only. This keeps the hold-off counter's assumption of a continuous request true, including the overlap case in R11.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] CODE_LF  = 8'h0A;
  localparam logic [KEY_W-1:0] CODE_CR  = 8'h0D;
  localparam logic [KEY_W-1:0] CODE_DEL = 8'h7F;
  localparam logic [KEY_W-1:0] CODE_BS  = 8'h08;

  // Translate a raw code and set the pending flag.
  function automatic logic [KEY_W-1:0] key_translate(input logic [KEY_W-1:0] raw);
    logic [KEY_W-1:0] t;
    if (raw == CODE_LF)       t = CODE_CR;
    else if (raw == CODE_DEL) t = CODE_BS;
    else                      t = raw;
    t[KEY_W-1] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/kbd_remap.sv
module kbd_remap
  import kbd_pkg::*;
(
  input  logic [KEY_W-1:0] raw_code,
  output logic [KEY_W-1:0] mapped_code
);
  always_comb mapped_code = key_translate(raw_code);
endmodule

// File: rtl/kbd_holdoff.sv
module kbd_holdoff #(
  parameter int HOLD_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,      // latch flag set
  input  logic req,       // producer valid
  input  logic take,      // transfer this cycle
  output logic expired
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!busy || !req || take) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kbd_bus_dec.sv
module kbd_bus_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC000,
  parameter logic [ADDR_W-1:0] STB_ADDR = 16'hC010
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_key,
  output logic              rd_stb,
  output logic              stb_any
);
  logic at_key, at_stb;
  assign at_key  = (addr == KEY_ADDR);
  assign at_stb  = (addr == STB_ADDR);
  assign rd_key  = rd && at_key;
  assign rd_stb  = rd && at_stb;
  assign stb_any = (rd || wr) && at_stb;
endmodule

// File: rtl/kbd_latch.sv
module kbd_latch
  import kbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC000,
  parameter logic [ADDR_W-1:0] STB_ADDR = 16'hC010,
  parameter int HOLD_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [7:0]        key_code,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  output logic              bus_rd_hit
);
  logic [KEY_W-1:0] latch_q;
  logic [KEY_W-1:0] mapped;
  logic rd_key, rd_stb, stb_any;
  logic expired, take;

  kbd_remap u_remap (
    .raw_code    (key_code),
    .mapped_code (mapped)
  );

  kbd_bus_dec #(
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR),
    .STB_ADDR (STB_ADDR)
  ) u_dec (
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .rd_key  (rd_key),
    .rd_stb  (rd_stb),
    .stb_any (stb_any)
  );

  kbd_holdoff #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (latch_q[KEY_W-1]),
    .req     (key_valid),
    .take    (take),
    .expired (expired)
  );

  assign key_ready = !latch_q[KEY_W-1] || expired;
  assign take      = key_valid && key_ready;

  // New key has priority over an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (take) begin
      latch_q <= mapped;
    end else if (stb_any) begin
      latch_q[KEY_W-1] <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata  = '0;
    bus_rd_hit = rd_key || rd_stb;
    if (rd_key)      bus_rdata = latch_q;
    else if (rd_stb) bus_rdata = {1'b0, latch_q[KEY_W-2:0]};
  end
endmodule

// File: rtl/kbd_latch_chk.sv
module kbd_latch_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC000,
  parameter logic [ADDR_W-1:0] STB_ADDR = 16'hC010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic              key_ready,
  input logic [7:0]        key_code,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              bus_rd_hit,
  input logic [7:0]        latch_q
);
  logic xfer, stb;
  assign xfer = key_valid && key_ready;
  assign stb  = (bus_rd || bus_wr) && (bus_addr == STB_ADDR);

  p_load_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> latch_q[7]);

  p_or_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && key_code != 8'h0A && key_code != 8'h7F) |=> latch_q == ($past(key_code) | 8'h80));

  p_lf_cr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && key_code == 8'h0A) |=> latch_q == 8'h8D);

  p_del_bs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && key_code == 8'h7F) |=> latch_q == 8'h88);

  p_stb_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STB_ADDR) |-> (bus_rd_hit && !bus_rdata[7]));

  p_stb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !xfer) |=> (!latch_q[7] && latch_q[6:0] == $past(latch_q[6:0])));

  p_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q[7] |-> key_ready);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !stb) |=> $stable(latch_q));

  p_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && stb) |=> latch_q[7]);

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_code)));
endmodule

bind kbd_latch kbd_latch_chk #(
  .ADDR_W   (ADDR_W),
  .KEY_ADDR (KEY_ADDR),
  .STB_ADDR (STB_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_valid  (key_valid),
  .key_ready  (key_ready),
  .key_code   (key_code),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .bus_rd_hit (bus_rd_hit),
  .latch_q    (latch_q)
);

// File: tb/sim_kbd_latch.sv
module sim_kbd_latch;
  localparam int HOLD = 8;
  localparam logic [15:0] KA = 16'hC000;
  localparam logic [15:0] SA = 16'hC010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic key_ready;
  logic [7:0] key_code = 8'h00;
  logic [15:0] bus_addr = 16'h0000;
  logic bus_rd = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic bus_rd_hit;

  int checks = 0;
  int fails = 0;
  logic [7:0] model;        // expected latch contents
  logic [7:0] exp_dat_q[$];
  logic       exp_hit_q[$];
  string      exp_tag_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  kbd_latch #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_rd_hit(bus_rd_hit)
  );

  function automatic logic [7:0] ref_map(input logic [7:0] c);
    logic [7:0] r;
    r = (c == 8'h0A) ? 8'h0D : (c == 8'h7F) ? 8'h08 : c;
    return r | 8'h80;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each read against the scoreboard queue.
  always @(negedge clk) begin
    #3;
    if (bus_rd) begin
      if (exp_dat_q.size() == 0) begin
        check(1'b0, "unexpected read", bus_rdata, 0);
      end else begin
        logic [7:0] d;
        logic h;
        string t;
        d = exp_dat_q.pop_front();
        h = exp_hit_q.pop_front();
        t = exp_tag_q.pop_front();
        check(bus_rdata == d && bus_rd_hit == h, t, {bus_rd_hit, bus_rdata}, {h, d});
      end
    end
  end

  task automatic bus_read(input logic [15:0] a, input string tag);
    logic [7:0] d;
    logic h;
    h = (a == KA) || (a == SA);
    d = (a == KA) ? model : (a == SA) ? {1'b0, model[6:0]} : 8'h00;
    exp_dat_q.push_back(d);
    exp_hit_q.push_back(h);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    if (a == SA) model[7] = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == SA) model[7] = 1'b0;
  endtask

  // Driver for the key stream; holds valid and code until taken (R12).
  task automatic send_key(input logic [7:0] c, output int waits);
    bit r;
    waits = 0;
    @(negedge clk);
    key_valid = 1'b1; key_code = c;
    forever begin
      #3;
      r = key_ready;
      @(negedge clk);
      if (r) break;
      waits++;
    end
    key_valid = 1'b0;
    model = ref_map(c);
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    model = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check(key_ready == 1'b1, "R1 ready after reset", key_ready, 1);
    bus_read(KA, "R1 reset latch");

    send_key(8'h41, w);
    check(w == 0, "R8 ready when empty", w, 0);
    bus_read(KA, "R2/R3 read key C1");
    bus_read(KA, "R2 read repeat");
    bus_read(SA, "R6 strobe read");
    bus_read(KA, "R6 flag cleared bits kept");
    @(negedge clk); #3;
    check(key_ready == 1'b1, "R8 ready after ack", key_ready, 1);

    send_key(8'h0A, w);
    bus_read(KA, "R4 LF to CR");
    bus_write(SA);
    bus_read(KA, "R7 strobe write clears");

    send_key(8'h7F, w);
    bus_read(KA, "R5 DEL to BS");
    bus_write(KA);
    bus_read(KA, "R10 data-address write ignored");
    bus_read(16'hC020, "R10 other address");
    bus_write(16'hC011);
    bus_read(KA, "R10 other write ignored");

    @(negedge clk); #3;
    check(key_ready == 1'b0, "R8 not ready while full", key_ready, 0);
    send_key(8'h42, w);
    check(w == HOLD, "R9 hold-off length", w, HOLD);
    bus_read(KA, "R9/R12 overwrite after hold-off");

    bus_read(SA, "R6 strobe read before overlap");
    // R11: transfer and strobe read in the same cycle
    exp_dat_q.push_back({1'b0, model[6:0]});
    exp_hit_q.push_back(1'b1);
    exp_tag_q.push_back("R11 overlap read");
    @(negedge clk);
    key_valid = 1'b1; key_code = 8'h33; bus_addr = SA; bus_rd = 1'b1;
    #3;
    check(key_ready == 1'b1, "R11 ready in overlap", key_ready, 1);
    @(negedge clk);
    key_valid = 1'b0; bus_rd = 1'b0;
    model = ref_map(8'h33);
    bus_read(KA, "R11 new key wins");

    bus_write(SA);
    send_key(8'hE5, w);
    bus_read(KA, "R3 input bit7 set");

    repeat (3) @(negedge clk);
    check(exp_dat_q.size() == 0, "scoreboard drained", exp_dat_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule